// File: doc/BRIEF.md
# Selectable-Polynomial PRBS Word Checker

The block compares a parallel word from a serial-link receiver against a pseudo-random binary sequence. A 4-bit select code picks the sequence at run time from six common polynomials, or turns checking off. The checker synchronizes itself. It fills a history register from the received bits. It then predicts each new bit from bits received earlier and flags every position where the received bit disagrees with the prediction. No transmitter seed has to be shared, and one flipped line bit causes only a short, fixed-size burst of mismatches.

There are three results. A per-word error flag is high only for a word that had at least one mismatch. A saturating bit-error counter adds the number of mismatched bits in each word, and an input can freeze it. A sticky lock flag rises once a programmable number of consecutive checked words have been clean. A loopback option sends the error flag to a transmit-side error-inject output in place of an external inject request, so jitter tolerance can be measured without crossing clock domains. After the select code changes, a counter reset must be issued so that the checker reseeds and starts looking for lock again.

Top module: `prbs_word_checker`

## Requirements
- R1: Select codes map to these polynomials, each as the bit recurrence s[k] = XOR of s[k-d] over its listed distances d:
  - 1: x^7+x^6+1, distances 7, 6
  - 2: x^9+x^5+1, distances 9, 5
  - 3: x^15+x^14+1, distances 15, 14
  - 4: x^23+x^18+1, distances 23, 18
  - 5: x^31+x^28+1, distances 31, 28
  - 6: x^13+x^12+x^2+x+1, distances 13, 12, 2, 1
- R2: With code 0 or any code from 7 to 15, a valid word never sets the error flag, never changes the counter and never moves the checker toward lock.
- R3: Bit 0 of each word is the earliest bit on the line. After reset or a counter reset, the first valid word only fills the history (when the data width is 31 or more) and is not checked.
- R4: The error flag is registered. It is high in the cycle after a checked valid word that contains at least one mismatch, and low after any other cycle.
- R5: The error counter is never decremented except by a reset. It adds the number of mismatched bits of each checked word and saturates at all-ones.
- R6: A high counter-stop input freezes the counter from that cycle on. The counter stays frozen until a counter reset, even after the stop input falls. The error flag keeps working while the counter is frozen.
- R7: The counter reset clears the counter, the stop state, the lock flag and the clean-run count, and makes the checker reseed. The word presented in that cycle is not checked.
- R8: Lock rises after the N-th consecutive clean checked word, where N is the 8-bit threshold input (0 acts as 1). A word with a mismatch before lock restarts the run.
- R9: Once high, the lock flag stays high whatever errors arrive, until reset or counter reset.
- R10: With loopback enabled, the inject output equals the error flag. Otherwise it equals the external inject input.
- R11: A single flipped line bit adds exactly 3 to the counter for two-tap polynomials and exactly 5 for code 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | DATA_W | Received word, bit 0 earliest |
| valid_i | input | 1 | Word strobe |
| pat_sel_i | input | 4 | Sequence select code |
| cnt_rst_i | input | 1 | Counter reset and resynchronize |
| cnt_stop_i | input | 1 | Freeze error counter |
| lock_thr_i | input | 8 | Clean words needed for lock |
| lb_en_i | input | 1 | Route error flag to inject output |
| tx_inj_i | input | 1 | External inject request |
| err_o | output | 1 | Per-word mismatch flag |
| err_cnt_o | output | CNT_W | Saturating bit-error count |
| lock_o | output | 1 | Sticky lock flag |
| tx_inj_o | output | 1 | Transmit error-inject output |

## Verification
The bench builds the checker with DATA_W = 32 and CNT_W = 8. With a 32-bit word, the whole 31-bit history fills from the first word, and error bursts can be placed either inside one word or across a word boundary. The 8-bit counter brings saturation within reach after about 85 words that carry single-bit errors. Every select code is swept, from 0 to 15. Each of the six sequences goes through the seed, lock and single-error paths, and expected counts come from the tap distances.

// File: rtl/prbs_chk_pkg.sv
`timescale 1ns/1ps
package prbs_chk_pkg;

    // Longest recurrence distance among the supported sequences.
    localparam int HIST_LEN = 31;
    localparam int TAP_W    = 5;

    typedef enum logic [2:0] {
        PAT_OFF,
        PAT_7,
        PAT_9,
        PAT_15,
        PAT_23,
        PAT_31,
        PAT_13
    } pat_e;

    // Recurrence distances; t2/t3 only count when four is set.
    typedef struct packed {
        logic             en;
        logic             four;
        logic [TAP_W-1:0] t0;
        logic [TAP_W-1:0] t1;
        logic [TAP_W-1:0] t2;
        logic [TAP_W-1:0] t3;
    } tap_cfg_t;

    function automatic pat_e decode_sel(input logic [3:0] code);
        case (code)
            4'd1:    return PAT_7;
            4'd2:    return PAT_9;
            4'd3:    return PAT_15;
            4'd4:    return PAT_23;
            4'd5:    return PAT_31;
            4'd6:    return PAT_13;
            default: return PAT_OFF;
        endcase
    endfunction

    function automatic tap_cfg_t make_cfg(input logic en, input logic four,
                                          input int a, input int b,
                                          input int c, input int d);
        tap_cfg_t r;
        r.en   = en;
        r.four = four;
        r.t0   = TAP_W'(a);
        r.t1   = TAP_W'(b);
        r.t2   = TAP_W'(c);
        r.t3   = TAP_W'(d);
        return r;
    endfunction

    function automatic tap_cfg_t taps_of(input pat_e p);
        case (p)
            PAT_7:   return make_cfg(1'b1, 1'b0, 7, 6, 1, 1);
            PAT_9:   return make_cfg(1'b1, 1'b0, 9, 5, 1, 1);
            PAT_15:  return make_cfg(1'b1, 1'b0, 15, 14, 1, 1);
            PAT_23:  return make_cfg(1'b1, 1'b0, 23, 18, 1, 1);
            PAT_31:  return make_cfg(1'b1, 1'b0, 31, 28, 1, 1);
            PAT_13:  return make_cfg(1'b1, 1'b1, 13, 12, 2, 1);
            default: return make_cfg(1'b0, 1'b0, 1, 1, 1, 1);
        endcase
    endfunction

endpackage

// File: rtl/prbs_history.sv
`timescale 1ns/1ps
module prbs_history
    import prbs_chk_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                resync,
    input  logic                valid,
    input  logic [HIST_LEN-1:0] hist_new,
    output logic [HIST_LEN-1:0] hist,
    output logic                primed
);
    localparam int FILL = (HIST_LEN + W - 1) / W;
    localparam int FCW  = $clog2(FILL + 1);

    logic [FCW-1:0] fill_cnt;

    assign primed = (fill_cnt == FCW'(FILL));

    always_ff @(posedge clk) begin
        if (rst) begin
            hist     <= '0;
            fill_cnt <= '0;
        end else begin
            if (valid) hist <= hist_new;
            if (resync)
                fill_cnt <= '0;
            else if (valid && !primed)
                fill_cnt <= fill_cnt + 1'b1;
        end
    end

    AST_RESYNC_UNPRIMED: assert property (@(posedge clk) disable iff (rst)
        resync |=> !primed); // R7

endmodule

// File: rtl/prbs_compare.sv
`timescale 1ns/1ps
module prbs_compare
    import prbs_chk_pkg::*;
#(
    parameter int W  = 32,
    parameter int PW = $clog2(W + 1)
) (
    input  logic [W-1:0]        data,
    input  logic [HIST_LEN-1:0] hist,
    input  tap_cfg_t            cfg,
    input  logic                check_en,
    output logic [W-1:0]        mis,
    output logic [PW-1:0]       mis_cnt
);
    localparam int XW = W + HIST_LEN;
    localparam int IW = $clog2(XW);

    logic [XW-1:0] ext;
    logic          pred;

    always_comb begin
        ext = {data, hist};
        for (int i = 0; i < W; i++) begin
            pred = ext[IW'(HIST_LEN + i - int'(cfg.t0))]
                 ^ ext[IW'(HIST_LEN + i - int'(cfg.t1))];
            if (cfg.four)
                pred = pred ^ ext[IW'(HIST_LEN + i - int'(cfg.t2))]
                            ^ ext[IW'(HIST_LEN + i - int'(cfg.t3))];
            mis[i] = check_en & (data[i] ^ pred);
        end
    end

    always_comb begin
        mis_cnt = '0;
        for (int i = 0; i < W; i++)
            mis_cnt = mis_cnt + PW'(mis[i]);
    end

endmodule

// File: rtl/prbs_err_counter.sv
`timescale 1ns/1ps
module prbs_err_counter #(
    parameter int CW = 32,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          stop,
    input  logic          add_en,
    input  logic [PW-1:0] add_val,
    output logic [CW-1:0] cnt
);
    logic          frozen;
    logic [CW:0]   sum;
    logic [CW-1:0] sat_sum;

    always_comb begin
        sum     = {1'b0, cnt} + (CW+1)'(add_val);
        sat_sum = sum[CW] ? '1 : sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt    <= '0;
            frozen <= 1'b0;
        end else begin
            if (stop) frozen <= 1'b1;
            if (add_en && !stop && !frozen) cnt <= sat_sum;
        end
    end

    AST_CNT_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
        !clr |=> cnt >= $past(cnt)); // R5
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (stop && !clr) |=> $stable(cnt)); // R6
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0); // R7

endmodule

// File: rtl/prbs_lock_tracker.sv
`timescale 1ns/1ps
module prbs_lock_tracker #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          chk,
    input  logic          err,
    input  logic [TW-1:0] thr,
    output logic          lock
);
    logic [TW-1:0] run;
    logic [TW-1:0] run_nxt;

    assign run_nxt = (run == '1) ? run : run + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run  <= '0;
            lock <= 1'b0;
        end else if (chk) begin
            if (err) begin
                if (!lock) run <= '0;
            end else begin
                run <= run_nxt;
                if (run_nxt >= thr) lock <= 1'b1;
            end
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (lock && !clr) |=> lock); // R9
    AST_LOCK_NEEDS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (!lock && !(chk && !err)) |=> !lock); // R8
    AST_LOCK_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> !lock); // R7

endmodule

// File: rtl/prbs_word_checker.sv
`timescale 1ns/1ps
module prbs_word_checker
    import prbs_chk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    input  logic [3:0]        pat_sel_i,
    input  logic              cnt_rst_i,
    input  logic              cnt_stop_i,
    input  logic [THR_W-1:0]  lock_thr_i,
    input  logic              lb_en_i,
    input  logic              tx_inj_i,
    output logic              err_o,
    output logic [CNT_W-1:0]  err_cnt_o,
    output logic              lock_o,
    output logic              tx_inj_o
);
    localparam int PW = $clog2(DATA_W + 1);

    tap_cfg_t            cfg;
    logic [HIST_LEN-1:0] hist;
    logic [HIST_LEN-1:0] hist_new;
    logic                primed;
    logic                check_en;
    logic [DATA_W-1:0]   mis;
    logic [PW-1:0]       mis_cnt;
    logic                word_bad;

    assign cfg      = taps_of(decode_sel(pat_sel_i));
    assign check_en = valid_i & primed & cfg.en & ~cnt_rst_i;
    assign word_bad = |mis;

    generate
        if (DATA_W >= HIST_LEN) begin : g_wide
            assign hist_new = data_i[DATA_W-1 -: HIST_LEN];
        end else begin : g_narrow
            assign hist_new = {data_i, hist[HIST_LEN-1 -: HIST_LEN-DATA_W]};
        end
    endgenerate

    prbs_history #(.W(DATA_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .resync   (cnt_rst_i),
        .valid    (valid_i),
        .hist_new (hist_new),
        .hist     (hist),
        .primed   (primed)
    );

    prbs_compare #(.W(DATA_W), .PW(PW)) u_cmp (
        .data     (data_i),
        .hist     (hist),
        .cfg      (cfg),
        .check_en (check_en),
        .mis      (mis),
        .mis_cnt  (mis_cnt)
    );

    prbs_err_counter #(.CW(CNT_W), .PW(PW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_rst_i),
        .stop    (cnt_stop_i),
        .add_en  (check_en),
        .add_val (mis_cnt),
        .cnt     (err_cnt_o)
    );

    prbs_lock_tracker #(.TW(THR_W)) u_lock (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_rst_i),
        .chk  (check_en),
        .err  (word_bad),
        .thr  (lock_thr_i),
        .lock (lock_o)
    );

    always_ff @(posedge clk) begin
        if (rst) err_o <= 1'b0;
        else     err_o <= word_bad;
    end

    assign tx_inj_o = lb_en_i ? err_o : tx_inj_i;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (pat_sel_i == 4'd0 || pat_sel_i > 4'd6)) |=> !err_o); // R2
    AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !err_o); // R4

endmodule

// File: tb/test_prbs_word_checker.sv
`timescale 1ns/1ps
module test_prbs_word_checker;
    localparam int W  = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [W-1:0]  data_i;
    logic          valid_i;
    logic [3:0]    pat_sel_i;
    logic          cnt_rst_i;
    logic          cnt_stop_i;
    logic [7:0]    lock_thr_i;
    logic          lb_en_i;
    logic          tx_inj_i;
    logic          err_o;
    logic [CW-1:0] err_cnt_o;
    logic          lock_o;
    logic          tx_inj_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] bsr;
    int          tp[4];
    int          ntp;

    always #2 clk = ~clk;

    prbs_word_checker #(.DATA_W(W), .CNT_W(CW)) i_prbs_word_checker (
        .clk(clk), .rst(rst), .data_i(data_i), .valid_i(valid_i),
        .pat_sel_i(pat_sel_i), .cnt_rst_i(cnt_rst_i), .cnt_stop_i(cnt_stop_i),
        .lock_thr_i(lock_thr_i), .lb_en_i(lb_en_i), .tx_inj_i(tx_inj_i),
        .err_o(err_o), .err_cnt_o(err_cnt_o), .lock_o(lock_o), .tx_inj_o(tx_inj_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Distances per select code (R1); the generator restarts from a fixed seed.
    task automatic set_pat(input logic [3:0] c);
        pat_sel_i = c;
        ntp = 2;
        case (c)
            4'd1: tp = '{7, 6, 1, 1};
            4'd2: tp = '{9, 5, 1, 1};
            4'd3: tp = '{15, 14, 1, 1};
            4'd4: tp = '{23, 18, 1, 1};
            4'd5: tp = '{31, 28, 1, 1};
            4'd6: begin tp = '{13, 12, 2, 1}; ntp = 4; end
            default: tp = '{7, 6, 1, 1};
        endcase
        bsr = 64'h5A3C_96F1_0F0F_1234;
    endtask

    task automatic gen(output logic [W-1:0] w);
        for (int b = 0; b < W; b++) begin
            logic nb;
            nb = 1'b0;
            for (int k = 0; k < ntp; k++) nb = nb ^ bsr[tp[k]-1];
            bsr  = {bsr[62:0], nb};
            w[b] = nb;
        end
    endtask

    task automatic send(input logic [W-1:0] d);
        @(negedge clk);
        data_i  = d;
        valid_i = 1'b1;
        @(posedge clk);
        #1;
        valid_i = 1'b0;
    endtask

    task automatic send_flip(input logic [W-1:0] m);
        logic [W-1:0] w;
        gen(w);
        send(w ^ m);
    endtask

    task automatic send_clean();
        send_flip('0);
    endtask

    task automatic pulse_rst_cnt();
        @(negedge clk);
        cnt_rst_i = 1'b1;
        @(posedge clk);
        #1;
        cnt_rst_i = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk);
        cnt_stop_i = 1'b1;
        @(posedge clk);
        #1;
        cnt_stop_i = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; data_i = '0; valid_i = 1'b0; pat_sel_i = 4'd0;
        cnt_rst_i = 1'b0; cnt_stop_i = 1'b0; lock_thr_i = 8'd4;
        lb_en_i = 1'b0; tx_inj_i = 1'b1;
        ntp = 2; tp = '{7, 6, 1, 1}; bsr = 64'h1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R4 reset err", err_o, 0);
        chk("R5 reset count", err_cnt_o, 0);
        chk("R8 reset lock", lock_o, 0);
        chk("R10 reset inject passthrough", tx_inj_o, 1);

        // R1 R8 R9 R11: sweep every sequence through seed, lock and one bit error.
        for (int c = 1; c <= 6; c++) begin
            lock_thr_i = 8'd4;
            set_pat(4'(c));
            pulse_rst_cnt();
            send_clean();
            chk($sformatf("R3 seed word code %0d err", c), err_o, 0);
            repeat (3) send_clean();
            chk($sformatf("R1 clean code %0d err", c), err_o, 0);
            chk($sformatf("R1 clean code %0d count", c), err_cnt_o, 0);
            chk($sformatf("R8 before threshold code %0d", c), lock_o, 0);
            send_clean();
            chk($sformatf("R8 at threshold code %0d", c), lock_o, 1);
            send_flip(32'h8);
            chk($sformatf("R4 error flag code %0d", c), err_o, 1);
            send_clean();
            send_clean();
            chk($sformatf("R4 flag falls code %0d", c), err_o, 0);
            chk($sformatf("R11 burst size code %0d", c), err_cnt_o, (c == 6) ? 5 : 3);
            chk($sformatf("R9 lock kept code %0d", c), lock_o, 1);
        end

        // R3: after a counter reset the first word is only a seed, even if random.
        set_pat(4'd1);
        pulse_rst_cnt();
        send(32'hDEAD_BEEF);
        chk("R3 random seed err", err_o, 0);
        chk("R3 random seed count", err_cnt_o, 0);

        // R8: an error before lock restarts the run; threshold 3.
        lock_thr_i = 8'd3;
        set_pat(4'd1);
        pulse_rst_cnt();
        send_clean();
        send_clean();
        send_clean();
        send_flip(32'h1);
        chk("R8 run cut by error", lock_o, 0);
        send_clean();
        send_clean();
        chk("R8 two clean after error", lock_o, 0);
        send_clean();
        chk("R8 three clean after error", lock_o, 1);
        chk("R5 in-word burst count", err_cnt_o, 3);
        pulse_rst_cnt();
        chk("R7 reset clears lock", lock_o, 0);
        chk("R7 reset clears count", err_cnt_o, 0);

        // R8: threshold 0 locks on the first clean checked word.
        lock_thr_i = 8'd0;
        set_pat(4'd3);
        pulse_rst_cnt();
        send_clean();
        chk("R8 thr0 seed no lock", lock_o, 0);
        send_clean();
        chk("R8 thr0 lock", lock_o, 1);

        // R2: off and invalid codes after one counted error.
        lock_thr_i = 8'd1;
        set_pat(4'd1);
        pulse_rst_cnt();
        send_clean();
        send_flip(32'h1);
        chk("R2 setup count", err_cnt_o, 3);
        for (int c = 0; c <= 15; c++) begin
            if (c >= 1 && c <= 6) continue;
            pat_sel_i = 4'(c);
            send($urandom());
            chk($sformatf("R2 code %0d err", c), err_o, 0);
            chk($sformatf("R2 code %0d count", c), err_cnt_o, 3);
        end
        chk("R2 no lock while off", lock_o, 0);

        // R6: stop freezes the counter until a counter reset.
        lock_thr_i = 8'd4;
        set_pat(4'd2);
        pulse_rst_cnt();
        send_clean();
        send_flip(32'h1);
        chk("R6 before stop", err_cnt_o, 3);
        pulse_stop();
        send_flip(32'h1);
        chk("R6 frozen count", err_cnt_o, 3);
        chk("R6 flag while frozen", err_o, 1);
        send_flip(32'h1);
        chk("R6 still frozen after stop falls", err_cnt_o, 3);
        pulse_rst_cnt();
        chk("R7 count cleared", err_cnt_o, 0);
        set_pat(4'd2);
        send_clean();
        send_flip(32'h1);
        chk("R6 counting resumes", err_cnt_o, 3);

        // R5: saturation with an 8-bit counter, 3 errors per word.
        set_pat(4'd1);
        pulse_rst_cnt();
        send_clean();
        for (int k = 1; k <= 90; k++) begin
            send_flip(32'h1);
            if (k == 84) chk("R5 below saturation", err_cnt_o, 252);
            if (k == 85) chk("R5 saturates", err_cnt_o, 255);
        end
        chk("R5 stays saturated", err_cnt_o, 255);

        // R10: loopback routing.
        set_pat(4'd1);
        pulse_rst_cnt();
        send_clean();
        lb_en_i = 1'b1;
        tx_inj_i = 1'b0;
        send_flip(32'h1);
        chk("R10 loopback follows error", tx_inj_o, 1);
        send_clean();
        chk("R10 loopback follows clean", tx_inj_o, 0);
        send_flip(32'h1);
        lb_en_i = 1'b0;
        #1;
        chk("R10 external inject low", tx_inj_o, 0);
        tx_inj_i = 1'b1;
        #1;
        chk("R10 external inject high", tx_inj_o, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule